// File: doc/BRIEF.md
# CAN Bus Fault Qualifier and Sticky Flags

This block turns raw fault-class indications from an analog bus monitor into confirmed, latched status flags. Seven indications arrive in parallel, one per fault class. A class is confirmed only when its indication stays asserted across a set number of qualifying bus transitions. A qualifying transition is a change from dominant to recessive that follows a dominant period of at least a minimum number of clock cycles.

Each confirmed class sets its own sticky bit in an 8-bit flag register. Software reads the flags and clears them with write-1-to-clear accesses over a small register port. A second register holds an interrupt enable mask. The interrupt output is asserted while any enabled flag is set.

Flag bit positions, with fault_i bit k feeding flag bit k:

| Bit | Fault class |
|-----|-------------|
| 0 | CANL shorted to battery, or both lines shorted to battery |
| 1 | CANH shorted to ground, or both lines shorted to ground |
| 2 | Bus open, which covers three separate open conditions |
| 3 | CANL shorted to ground |
| 4 | CANH shorted to battery |
| 5 | CANH shorted to CANL |
| 6 | One termination point open |
| 7 | Reserved |

Top module: `can_fault_flags`

## Requirements
- R1: After reset the flag register reads 0x00, the enable register reads 0x7F and irq_o is 0.
- R2: A dominant-to-recessive transition qualifies only if bus_dom_i was 1 for at least MIN_DOM_CYC consecutive sampled cycles immediately before the first sampled 0.
- R3: Flag bit k is set on the clock edge that samples the QUAL_EDGES-th qualifying transition (default 4), provided fault_i[k] is 1 on every sampled cycle from the first of those transitions through the last. The flag is readable from the next cycle.
- R4: If fault_i[k] is 0 on any sampled cycle, the qualification progress of class k restarts from zero.
- R5: A dominant period shorter than MIN_DOM_CYC neither advances nor resets the progress of any class.
- R6: A write to address 0 clears every flag bit whose data bit is 1. A data bit of 0 leaves that flag bit unchanged.
- R7: A set flag stays set after its fault indication goes away, until software clears it.
- R8: If a confirmation and a clearing write to the same bit fall on the same clock edge, the bit ends up set.
- R9: After confirmation, a class that stays present does not set its flag again, whatever transitions follow. The indication must go to 0 and then qualify again from zero.
- R10: irq_o is 1 exactly when some flag bit k is set and enable bit k (address 1) is also set. The enable register reads back the last value written to it.
- R11: Flag bit 7 always reads 0, including after a write of 0xFF to address 0.
- R12: Each class qualifies independently, and fault_i bit k drives only flag bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_dom_i | input | 1 | Bus state: 1 = dominant, 0 = recessive |
| fault_i | input | 7 | Fault-class indications from the analog monitor |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 = flags, 1 = interrupt enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with MIN_DOM_CYC = 4 and QUAL_EDGES = 4. With these values, a sweep of dominant lengths from 1 to 6 cycles covers both sides of the qualification threshold. A second sweep runs every one of the seven classes through full confirmation, clearing and interrupt masking. Directed sequences cover partial counts, indication dropouts, interleaved short pulses, saturation after confirmation, and a clearing write that falls on the same edge as the final transition.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
  localparam int unsigned NUM_CLASSES = 7;
  localparam int unsigned REG_W       = 8;
  localparam logic        ADDR_FLAGS  = 1'b0;
  localparam logic        ADDR_IRQ_EN = 1'b1;
  localparam logic [REG_W-1:0] IRQ_EN_RESET = 8'h7F;
endpackage

// File: rtl/can_dom_qualifier.sv
module can_dom_qualifier #(
  parameter int unsigned MIN_DOM_CYC = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_dom_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_DOM_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_DOM_CYC);

  logic [CW-1:0] dom_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dom_cnt_q <= '0;
    else if (!bus_dom_i)        dom_cnt_q <= '0;
    else if (dom_cnt_q != CMAX) dom_cnt_q <= dom_cnt_q + 1'b1;
  end

  // counter is non-zero only when the previous sample was dominant
  assign qual_o = !bus_dom_i && (dom_cnt_q == CMAX);
endmodule

// File: rtl/can_fault_counter.sv
module can_fault_counter #(
  parameter int unsigned QUAL_EDGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic qual_i,
  output logic confirm_o
);
  localparam int unsigned CW = $clog2(QUAL_EDGES + 1);
  localparam logic [CW-1:0] CSAT = CW'(QUAL_EDGES);
  localparam logic [CW-1:0] CLAST = CW'(QUAL_EDGES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!fault_i)               cnt_q <= '0;
    else if (qual_i && cnt_q != CSAT) cnt_q <= cnt_q + 1'b1;
  end

  assign confirm_o = fault_i && qual_i && (cnt_q == CLAST);
endmodule

// File: rtl/can_fault_regs.sv
module can_fault_regs
  import can_fault_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CLASSES-1:0] set_i,
  input  logic                   reg_we_i,
  input  logic                   reg_addr_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [NUM_CLASSES-1:0] flags_o,
  output logic [REG_W-1:0]       irq_en_o
);
  logic [NUM_CLASSES-1:0] clr;

  assign clr = (reg_we_i && reg_addr_i == ADDR_FLAGS) ? reg_wdata_i[NUM_CLASSES-1:0] : '0;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    irq_en_o <= IRQ_EN_RESET;
    else if (reg_we_i && reg_addr_i == ADDR_IRQ_EN) irq_en_o <= reg_wdata_i;
  end
endmodule

// File: rtl/can_fault_flags.sv
module can_fault_flags
  import can_fault_pkg::*;
#(
  parameter int unsigned MIN_DOM_CYC = 80,
  parameter int unsigned QUAL_EDGES  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_dom_i,
  input  logic [NUM_CLASSES-1:0] fault_i,
  input  logic                   reg_we_i,
  input  logic                   reg_addr_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [REG_W-1:0]       reg_rdata_o,
  output logic                   irq_o
);
  localparam int unsigned PAD_W = REG_W - NUM_CLASSES;

  logic                   qual;
  logic [NUM_CLASSES-1:0] confirm;
  logic [NUM_CLASSES-1:0] flags;
  logic [REG_W-1:0]       irq_en;

  can_dom_qualifier #(.MIN_DOM_CYC(MIN_DOM_CYC)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_dom_i(bus_dom_i),
    .qual_o   (qual)
  );

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
    can_fault_counter #(.QUAL_EDGES(QUAL_EDGES)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fault_i  (fault_i[k]),
      .qual_i   (qual),
      .confirm_o(confirm[k])
    );
  end

  can_fault_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (confirm),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .flags_o    (flags),
    .irq_en_o   (irq_en)
  );

  assign reg_rdata_o = (reg_addr_i == ADDR_IRQ_EN) ? irq_en : {{PAD_W{1'b0}}, flags};
  assign irq_o = |(flags & irq_en[NUM_CLASSES-1:0]);
endmodule

// File: rtl/can_fault_flags_chk.sv
module can_fault_flags_chk
  import can_fault_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_CLASSES-1:0] fault_i,
  input logic                   reg_we_i,
  input logic                   reg_addr_i,
  input logic [REG_W-1:0]       reg_wdata_i,
  input logic [REG_W-1:0]       reg_rdata_o,
  input logic [NUM_CLASSES-1:0] flags,
  input logic [REG_W-1:0]       irq_en,
  input logic                   irq_o
);
  // R11
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_FLAGS) |-> (reg_rdata_o[REG_W-1] == 1'b0));

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == ADDR_FLAGS) |=> (($past(flags) & ~flags) == '0));

  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_FLAGS) |=>
      ((flags & $past(reg_wdata_i[NUM_CLASSES-1:0]) & ~$past(fault_i)) == '0));

  // R3
  set_needs_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(fault_i)) == '0));

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flags & irq_en[NUM_CLASSES-1:0]) != '0));
endmodule

bind can_fault_flags can_fault_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fault_i    (fault_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .flags      (flags),
  .irq_en     (irq_en),
  .irq_o      (irq_o)
);

// File: tb/can_fault_flags_tb_top.sv
module can_fault_flags_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_DOM = 4;
  localparam int QE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_dom = 1'b0;
  logic [6:0] fault = '0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_flags #(.MIN_DOM_CYC(MIN_DOM), .QUAL_EDGES(QE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_dom_i(bus_dom), .fault_i(fault),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic chk_reg(string req, logic a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0; addr = 1'b0;
  endtask

  // dominant for d samples, then recessive; optional clear write on the edge sample
  task automatic pulse(int d, bit clr_edge = 1'b0, logic [7:0] mask = '0);
    repeat (d) begin bus_dom = 1'b1; @(negedge clk); end
    bus_dom = 1'b0;
    if (clr_edge) begin we = 1'b1; addr = 1'b0; wdata = mask; end
    @(negedge clk);
    we = 1'b0; wdata = '0;
    @(negedge clk);
  endtask

  task automatic pulses(int n, int d);
    repeat (n) pulse(d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk_reg("R1 flags", 1'b0, 8'h00);
    chk_reg("R1 enable", 1'b1, 8'h7F);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 sweep dominant length across threshold
    for (int d = 1; d <= MIN_DOM + 2; d++) begin
      fault = 7'h01;
      pulses(QE, d);
      chk_reg($sformatf("R2 len %0d", d), 1'b0, (d >= MIN_DOM) ? 8'h01 : 8'h00);
      fault = '0;
      @(negedge clk);
      wr(1'b0, 8'h7F);
    end

    // R12 / R10 per-class sweep
    for (int k = 0; k < 7; k++) begin
      fault = 7'(1 << k);
      pulses(QE - 1, MIN_DOM);
      chk_reg($sformatf("R3 partial class %0d", k), 1'b0, 8'h00);
      pulse(MIN_DOM);
      chk_reg($sformatf("R12 class %0d", k), 1'b0, 8'(1 << k));
      chk($sformatf("R10 irq class %0d", k), {7'b0, irq}, 8'h01);
      wr(1'b1, ~8'(1 << k));
      chk($sformatf("R10 masked class %0d", k), {7'b0, irq}, 8'h00);
      wr(1'b1, 8'h7F);
      fault = '0;
      @(negedge clk);
      wr(1'b0, 8'(1 << k));
      chk_reg($sformatf("R6 clear class %0d", k), 1'b0, 8'h00);
    end

    // R4 dropout restarts count
    fault = 7'h04;
    pulses(2, MIN_DOM);
    fault = '0; @(negedge clk); fault = 7'h04;
    pulses(2, MIN_DOM);
    chk_reg("R4 after dropout", 1'b0, 8'h00);
    pulses(2, MIN_DOM);
    chk_reg("R4 reconfirm", 1'b0, 8'h04);
    fault = '0; @(negedge clk);
    // R7 sticky
    chk_reg("R7 sticky", 1'b0, 8'h04);
    // R6 zero write no effect
    wr(1'b0, 8'h00);
    chk_reg("R6 write zero", 1'b0, 8'h04);
    wr(1'b0, 8'h04);

    // R5 short pulses neither advance nor reset
    fault = 7'h10;
    pulses(2, MIN_DOM);
    pulse(MIN_DOM - 1);
    pulse(1);
    pulse(MIN_DOM);
    chk_reg("R5 three qualifying", 1'b0, 8'h00);
    pulse(MIN_DOM);
    chk_reg("R5 fourth", 1'b0, 8'h10);

    // R9 no re-set while held
    wr(1'b0, 8'h10);
    pulses(QE + 1, MIN_DOM);
    chk_reg("R9 held", 1'b0, 8'h00);
    fault = '0; @(negedge clk); fault = 7'h10;
    pulses(QE, MIN_DOM);
    chk_reg("R9 requalify", 1'b0, 8'h10);
    fault = '0; @(negedge clk);
    wr(1'b0, 8'h10);

    // R8 set beats clear on same edge
    fault = 7'h40;
    pulses(QE - 1, MIN_DOM);
    pulse(MIN_DOM, 1'b1, 8'h40);
    chk_reg("R8 set wins", 1'b0, 8'h40);
    fault = '0; @(negedge clk);

    // R11 reserved bit
    wr(1'b0, 8'hFF);
    chk_reg("R11 bit7", 1'b0, 8'h00);
    // R10 enable readback
    wr(1'b1, 8'hA5);
    chk_reg("R10 enable readback", 1'b1, 8'hA5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule